// File: doc/BRIEF.md
# SPI Command Frame Engine

This block is the SPI master side of a link to a smart low-side output driver. A client gives it one request at a time: either a write, made of a 5-bit register address and an 8-bit data byte, or a read, made of a 5-bit sub-address. The engine builds the 16-bit command word and sets its parity bit. It shifts the word out most significant bit first, with chip select held low for exactly one word. While doing so it captures the 16-bit reply from the device. The serial clock comes from the system clock through a parameterised divider. Chip select is then kept high for a programmable minimum time before the next word can start.

The device answers each word one frame late: the reply clocked back during a transfer belongs to the request sent in the frame before it. The engine therefore remembers whether the previous frame was a read, and if so which sub-address it named. It checks each reply for three faults: overall parity, the device error flag, and, after a read, the echoed sub-address. It reports the result with a single-cycle done pulse that carries the raw reply, its data byte and a 2-bit status code. It also keeps one wrapping counter for each type of fault. The reply's data byte is passed through without any interpretation.

Top module: `spi_frame_engine`

## Requirements
- R1: A write frame carries the address in bits 14:10 and the data byte in bits 8:1, and sends bits 15 and 9 as zero.
- R2: Bit 0 of every outgoing frame is set so that the whole 16-bit word has an odd number of ones.
- R3: A read request (`req_read`=1) is sent as address 0x10 with the sub-address (`req_addr`) in bits 5:1 and zeros in bits 8:6.
- R4: `sclk` idles low. `cs_n` falls before the first rising `sclk` edge and stays low for exactly 16 rising edges. `mosi` presents bit 15 first, and both sides sample on rising edges.
- R5: Between two frames `cs_n` stays high for at least CS_GAP clock cycles. `req_ready` is high only while `cs_n` is high and no frame is in progress.
- R6: A reply with an even number of ones reports status 1 (parity error) and increments `cnt_parity`. This check takes precedence over all others.
- R7: A reply with correct parity and bit 15 set reports status 2 (device frame error) and increments `cnt_frame`.
- R8: When the previous frame was a read, a reply with correct parity and bit 15 clear must have bit 9 set and the previous sub-address in bits 14:10. Otherwise it reports status 3 (address mismatch) and increments `cnt_addr`.
- R9: After a frame whose address was not 0x10, and after reset, the next reply's address field and bit 9 are ignored. Reset also clears all three counters.
- R10: One cycle after `cs_n` rises, `done` is high for exactly one cycle. With it, `rsp_word` holds the captured reply, `rsp_data` holds reply bits 8:1, and `rsp_status` holds the code (0 = OK).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_read | input | 1 | 1 = read of sub-address `req_addr`, 0 = write |
| req_addr | input | 5 | Register address (write) or sub-address (read) |
| req_data | input | 8 | Write data byte |
| req_ready | output | 1 | Engine idle and accepting a request |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| done | output | 1 | Single-cycle reply-ready pulse |
| rsp_word | output | 16 | Captured reply word |
| rsp_data | output | 8 | Reply bits 8:1 |
| rsp_status | output | 2 | 0 OK, 1 parity, 2 frame error, 3 address mismatch |
| cnt_parity | output | CNT_W | Parity error count |
| cnt_frame | output | CNT_W | Device frame error count |
| cnt_addr | output | CNT_W | Address mismatch count |

## Verification
The outgoing word can only be compared once all 16 rising `sclk` edges have passed. The reply verdict is due exactly one clock after `cs_n` rises. The bench therefore queues the expected word, status and counter values when it issues a request. The monitor pops that entry only on the cycle `done` is seen, and checks that this cycle directly follows the one in which `cs_n` went high. The bench keeps its own record of the previous request, so the expected verdict follows the one-frame-late reply rule. The high time of `cs_n` between frames and the rising-edge count within each frame are measured on the pins.

// File: rtl/sfe_pkg.sv
// Shared constants and types for the SPI command frame engine.
// Assumes 16-bit frames with a 5-bit address field and an 8-bit data field.
package sfe_pkg;
    localparam int          FRAME_W   = 16;
    localparam logic [4:0]  READ_ADDR = 5'h10;
    localparam logic [4:0]  SUB_NONE  = 5'h1F;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_PARITY = 2'd1,
        ST_FRAME  = 2'd2,
        ST_ADDR   = 2'd3
    } sfe_status_e;
endpackage

// File: rtl/sfe_frame_build.sv
// Builds the outgoing 16-bit command word from a request, including odd parity.
// Assumes the request fields are stable while the word is used (pure combinational).
module sfe_frame_build
    import sfe_pkg::*;
(
    input  logic                rd,
    input  logic [4:0]          addr,
    input  logic [7:0]          data,
    output logic [FRAME_W-1:0]  frame,
    output logic                is_read,
    output logic [4:0]          sub
);
    logic [4:0]         f_addr;
    logic [7:0]         f_data;
    logic [FRAME_W-1:0] body;

    // Select address/data fields and append the parity bit.
    always_comb begin
        f_addr  = rd ? READ_ADDR : addr;
        f_data  = rd ? {3'b000, addr} : data;
        body    = {1'b0, f_addr, 1'b0, f_data, 1'b0};
        frame   = {body[FRAME_W-1:1], ~^body[FRAME_W-1:1]};
        is_read = (f_addr == READ_ADDR);
        sub     = f_data[4:0];
    end
endmodule

// File: rtl/sfe_spi_shifter.sv
// SPI mode-0 master for one 16-bit word per chip-select window, with clock divider
// and minimum chip-select high time. Assumes HALF_DIV >= 1 and CS_GAP >= 1.
module sfe_spi_shifter
    import sfe_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int CS_GAP   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_word,
    output logic               ready,
    output logic               sclk,
    output logic               cs_n,
    output logic               mosi,
    input  logic               miso,
    output logic               xfer_done,
    output logic [FRAME_W-1:0] rx_word
);
    localparam int MAXC = (HALF_DIV > CS_GAP) ? HALF_DIV : CS_GAP;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] TICK_AT = CW'(HALF_DIV - 1);
    localparam logic [CW-1:0] GAP_END = CW'(CS_GAP - 1);
    localparam int BW = $clog2(FRAME_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

    typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_TAIL, S_GAP} sh_state_e;

    sh_state_e          st;
    logic [CW-1:0]      tmr;
    logic [BW-1:0]      bit_cnt;
    logic [FRAME_W-1:0] tx_sh, rx_sh;
    logic               sclk_q, cs_q, done_q;
    logic               tick;

    assign tick = (tmr == TICK_AT);

    // Frame sequencer: setup, 16 clock periods, hold, then chip-select gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; tmr <= '0; bit_cnt <= '0;
            tx_sh <= '0; rx_sh <= '0;
            sclk_q <= 1'b0; cs_q <= 1'b1; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                S_IDLE: begin
                    tmr <= '0;
                    if (start) begin
                        tx_sh <= tx_word; cs_q <= 1'b0; bit_cnt <= '0; st <= S_LEAD;
                    end
                end
                S_LEAD: begin
                    if (tick) begin
                        tmr <= '0; sclk_q <= 1'b1;
                        rx_sh <= {rx_sh[FRAME_W-2:0], miso}; st <= S_SHIFT;
                    end else tmr <= tmr + 1'b1;
                end
                S_SHIFT: begin
                    if (tick) begin
                        tmr <= '0;
                        if (sclk_q) begin
                            sclk_q <= 1'b0;
                            if (bit_cnt == LAST_BIT) st <= S_TAIL;
                            else begin
                                bit_cnt <= bit_cnt + 1'b1;
                                tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
                            end
                        end else begin
                            sclk_q <= 1'b1;
                            rx_sh  <= {rx_sh[FRAME_W-2:0], miso};
                        end
                    end else tmr <= tmr + 1'b1;
                end
                S_TAIL: begin
                    if (tick) begin
                        tmr <= '0; cs_q <= 1'b1; done_q <= 1'b1; st <= S_GAP;
                    end else tmr <= tmr + 1'b1;
                end
                default: begin
                    if (tmr == GAP_END) begin tmr <= '0; st <= S_IDLE; end
                    else tmr <= tmr + 1'b1;
                end
            endcase
        end
    end

    assign ready     = (st == S_IDLE);
    assign sclk      = sclk_q;
    assign cs_n      = cs_q;
    assign mosi      = cs_q ? 1'b0 : tx_sh[FRAME_W-1];
    assign xfer_done = done_q;
    assign rx_word   = rx_sh;

    // R4
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    // R5
    ready_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> cs_n);
endmodule

// File: rtl/sfe_reply_check.sv
// Validates each captured reply against the request of the previous frame,
// produces the done pulse with status, and keeps per-fault counters.
// Assumes xfer_done pulses once per frame with sent_read/sent_sub of that frame.
module sfe_reply_check
    import sfe_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xfer_done,
    input  logic [FRAME_W-1:0] rx_word,
    input  logic               sent_read,
    input  logic [4:0]         sent_sub,
    output logic               done,
    output logic [FRAME_W-1:0] rsp_word,
    output logic [7:0]         rsp_data,
    output logic [1:0]         rsp_status,
    output logic [CNT_W-1:0]   cnt_parity,
    output logic [CNT_W-1:0]   cnt_frame,
    output logic [CNT_W-1:0]   cnt_addr
);
    logic        prev_read;
    logic [4:0]  prev_sub;
    sfe_status_e verdict, status_q;

    // Classify the reply: parity, then device flag, then echoed sub-address.
    always_comb begin
        if (~^rx_word)                  verdict = ST_PARITY;
        else if (rx_word[15])           verdict = ST_FRAME;
        else if (prev_read && (!rx_word[9] || rx_word[14:10] != prev_sub))
                                        verdict = ST_ADDR;
        else                            verdict = ST_OK;
    end

    // Register result, bump the matching counter, remember this frame's request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0; rsp_word <= '0; status_q <= ST_OK;
            cnt_parity <= '0; cnt_frame <= '0; cnt_addr <= '0;
            prev_read <= 1'b0; prev_sub <= SUB_NONE;
        end else begin
            done <= xfer_done;
            if (xfer_done) begin
                rsp_word  <= rx_word;
                status_q  <= verdict;
                prev_read <= sent_read;
                prev_sub  <= sent_read ? sent_sub : SUB_NONE;
                case (verdict)
                    ST_PARITY: cnt_parity <= cnt_parity + 1'b1;
                    ST_FRAME:  cnt_frame  <= cnt_frame + 1'b1;
                    ST_ADDR:   cnt_addr   <= cnt_addr + 1'b1;
                    default:   ;
                endcase
            end
        end
    end

    assign rsp_data   = rsp_word[8:1];
    assign rsp_status = status_q;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    parity_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(^rsp_word)) |-> (rsp_status == 2'd1));
    // R6
    cnt_parity_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_parity != $past(cnt_parity)) |-> done);
    // R8
    cnt_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_addr != $past(cnt_addr)) |-> (done && rsp_status == 2'd3));
endmodule

// File: rtl/spi_frame_engine.sv
// Top of the SPI command frame engine: accepts one request when idle, sends the
// parity-protected word, and checks the reply against the previous frame.
// Assumes the client holds request fields valid while req_valid is high.
module spi_frame_engine
    import sfe_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int CS_GAP   = 6,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_read,
    input  logic [4:0]       req_addr,
    input  logic [7:0]       req_data,
    output logic             req_ready,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso,
    output logic             done,
    output logic [15:0]      rsp_word,
    output logic [7:0]       rsp_data,
    output logic [1:0]       rsp_status,
    output logic [CNT_W-1:0] cnt_parity,
    output logic [CNT_W-1:0] cnt_frame,
    output logic [CNT_W-1:0] cnt_addr
);
    logic [FRAME_W-1:0] tx_frame, rx_word;
    logic               f_is_read, start, xfer_done;
    logic [4:0]         f_sub;
    logic               cur_read;
    logic [4:0]         cur_sub;

    assign start = req_valid && req_ready;

    sfe_frame_build u_build (
        .rd(req_read), .addr(req_addr), .data(req_data),
        .frame(tx_frame), .is_read(f_is_read), .sub(f_sub)
    );

    // Hold the read flag and sub-address of the frame in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_read <= 1'b0; cur_sub <= SUB_NONE;
        end else if (start) begin
            cur_read <= f_is_read; cur_sub <= f_sub;
        end
    end

    sfe_spi_shifter #(.HALF_DIV(HALF_DIV), .CS_GAP(CS_GAP)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_frame),
        .ready(req_ready), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .xfer_done(xfer_done), .rx_word(rx_word)
    );

    sfe_reply_check #(.CNT_W(CNT_W)) u_check (
        .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .rx_word(rx_word),
        .sent_read(cur_read), .sent_sub(cur_sub),
        .done(done), .rsp_word(rsp_word), .rsp_data(rsp_data),
        .rsp_status(rsp_status), .cnt_parity(cnt_parity),
        .cnt_frame(cnt_frame), .cnt_addr(cnt_addr)
    );
endmodule

// File: tb/spi_frame_engine_bench.sv
module spi_frame_engine_bench;
    localparam int CS_GAP = 6;
    localparam int CNT_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_read = 1'b0;
    logic [4:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic req_ready, sclk, cs_n, mosi, done;
    logic miso;
    logic [15:0] rsp_word;
    logic [7:0]  rsp_data;
    logic [1:0]  rsp_status;
    logic [CNT_W-1:0] cnt_parity, cnt_frame, cnt_addr;

    always #4 clk = ~clk;

    spi_frame_engine #(.HALF_DIV(4), .CS_GAP(CS_GAP), .CNT_W(CNT_W)) u_spi_frame_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .done(done),
        .rsp_word(rsp_word), .rsp_data(rsp_data), .rsp_status(rsp_status),
        .cnt_parity(cnt_parity), .cnt_frame(cnt_frame), .cnt_addr(cnt_addr)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [15:0] slv_reply = '0, slv_rx = '0;
    int slv_idx = 0, slv_edges = 0;
    logic miso_q = 1'b0;
    assign miso = miso_q;

    always @(negedge cs_n) begin
        slv_idx = 15; miso_q = slv_reply[15]; slv_rx = '0; slv_edges = 0;
    end
    always @(negedge sclk) if (cs_n === 1'b0 && slv_idx > 0) begin
        slv_idx--; miso_q = slv_reply[slv_idx];
    end
    always @(posedge sclk) if (cs_n === 1'b0) begin
        slv_rx = {slv_rx[14:0], mosi}; slv_edges++;
    end

    // ---------------- scoreboard ----------------
    typedef struct packed {
        logic [15:0] mosi_w;
        logic [15:0] reply;
        logic [1:0]  status;
        logic [7:0]  cp, cf, ca;
    } exp_t;
    exp_t q[$];
    int exp_p = 0, exp_f = 0, exp_a = 0;
    bit prev_rd = 0;
    logic [4:0] prev_sub = '0;

    function automatic logic [15:0] mk_frame(input bit rd, input logic [4:0] a,
                                             input logic [7:0] d);
        logic [4:0] fa; logic [7:0] fd; logic [15:0] w;
        fa = rd ? 5'h10 : a;               // R3 read address
        fd = rd ? {3'b000, a} : d;         // R3 sub-address in bits 5:1
        w  = {1'b0, fa, 1'b0, fd, 1'b0};   // R1 layout
        w[0] = ~^w;                        // R2 odd total
        return w;
    endfunction

    function automatic logic [15:0] mk_reply(input bit b15, input logic [4:0] a,
                                             input bit b9, input logic [7:0] d,
                                             input bit good);
        logic [15:0] w;
        w = {b15, a, b9, d, 1'b0};
        w[0] = good ? ~^w : ^w;
        return w;
    endfunction

    task automatic send(input bit rd, input logic [4:0] a, input logic [7:0] d,
                        input logic [15:0] reply);
        exp_t e;
        logic [1:0] st;
        if ($countones(reply) % 2 == 0)                 st = 2'd1;  // R6
        else if (reply[15])                             st = 2'd2;  // R7
        else if (prev_rd && (!reply[9] || reply[14:10] != prev_sub)) st = 2'd3; // R8
        else                                            st = 2'd0;  // R9
        if (st == 2'd1) exp_p++;
        if (st == 2'd2) exp_f++;
        if (st == 2'd3) exp_a++;
        prev_rd  = rd || (a == 5'h10);
        prev_sub = rd ? a : d[4:0];
        e.mosi_w = mk_frame(rd, a, d);
        e.reply = reply; e.status = st;
        e.cp = 8'(exp_p); e.cf = 8'(exp_f); e.ca = 8'(exp_a);
        q.push_back(e);
        slv_reply = reply;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_read = rd; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
    endtask

    int cyc = 0, rose_cyc = -10, hi_run = 0, frames = 0;
    logic cs_prev = 1'b1, done_prev = 1'b0;

    // Monitor: samples on falling clock edge, pops one expectation per done.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cs_prev === 1'b0 && cs_n === 1'b1) rose_cyc = cyc;
            if (cs_prev === 1'b1 && cs_n === 1'b0) begin
                if (frames > 0)
                    chk(hi_run >= CS_GAP, "R5", "cs_n high cycles", hi_run, CS_GAP);
                frames++;
            end
            if (cs_n === 1'b1) hi_run++; else hi_run = 0;
            if (done === 1'b1) begin
                exp_t e;
                if (q.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
                else begin
                    e = q.pop_front();
                    chk(done_prev == 1'b0, "R10", "done pulse width", done_prev, 0);
                    chk(cyc == rose_cyc + 1, "R10", "done timing", cyc - rose_cyc, 1);
                    chk(slv_rx == e.mosi_w, "R1 R2 R3", "mosi word", slv_rx, e.mosi_w);
                    chk(slv_edges == 16, "R4", "sclk rising edges", slv_edges, 16);
                    chk(rsp_word == e.reply, "R10", "rsp_word", rsp_word, e.reply);
                    chk(rsp_data == e.reply[8:1], "R10", "rsp_data", rsp_data, e.reply[8:1]);
                    chk(rsp_status == e.status, "R6 R7 R8 R9", "rsp_status", rsp_status, e.status);
                    chk(cnt_parity == e.cp, "R6", "cnt_parity", cnt_parity, e.cp);
                    chk(cnt_frame == e.cf, "R7", "cnt_frame", cnt_frame, e.cf);
                    chk(cnt_addr == e.ca, "R8", "cnt_addr", cnt_addr, e.ca);
                end
            end
        end else begin
            hi_run = 0; frames = 0;
        end
        cs_prev = cs_n; done_prev = done;
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        exp_p = 0; exp_f = 0; exp_a = 0; prev_rd = 0; prev_sub = '0;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 R5 R4 R9 reset state
        chk(cs_n === 1'b1, "R4", "reset cs_n", cs_n, 1);
        chk(sclk === 1'b0, "R4", "reset sclk", sclk, 0);
        chk(done === 1'b0, "R10", "reset done", done, 0);
        chk(req_ready === 1'b1, "R5", "reset req_ready", req_ready, 1);
        chk(cnt_parity == 0 && cnt_frame == 0 && cnt_addr == 0, "R9", "reset counters",
            cnt_parity + cnt_frame + cnt_addr, 0);
        rst_n = 1'b1;
        // R1 R2 R9: write after reset, garbage address in reply ignored
        send(0, 5'h08, 8'hA5, mk_reply(0, 5'h13, 0, 8'h11, 1));
        // R6: even parity reply
        send(0, 5'h0D, 8'h02, mk_reply(0, 5'h00, 0, 8'h00, 0));
        // R3 R7: read; reply carries device error flag
        send(1, 5'h05, 8'hFF, mk_reply(1, 5'h00, 0, 8'h3C, 1));
        // R8 pass: previous read sub 0x05 echoed with bit 9
        send(0, 5'h0C, 8'h00, mk_reply(0, 5'h05, 1, 8'h5A, 1));
        // R9: previous was a write, mismatch ignored
        send(1, 5'h1F, 8'h00, mk_reply(0, 5'h02, 0, 8'h81, 1));
        // R8 pass with sub 0x1F
        send(1, 5'h03, 8'h00, mk_reply(0, 5'h1F, 1, 8'hC3, 1));
        // R8: wrong sub-address echoed
        send(0, 5'h09, 8'hFF, mk_reply(0, 5'h04, 1, 8'h00, 1));
        // R9: after write, no check
        send(1, 5'h02, 8'h00, mk_reply(0, 5'h11, 0, 8'h7E, 1));
        // R8: bit 9 missing though sub matches
        send(0, 5'h0A, 8'h00, mk_reply(0, 5'h02, 0, 8'h01, 1));
        // R6 precedence over R7
        send(0, 5'h0B, 8'h3C, mk_reply(1, 5'h00, 0, 8'h00, 0));
        // R9: reset after a read clears tracking and counters
        send(1, 5'h07, 8'h00, mk_reply(0, 5'h00, 0, 8'h00, 1));
        do_reset();
        chk(cnt_parity == 0 && cnt_frame == 0 && cnt_addr == 0, "R9",
            "counters after reset", cnt_parity + cnt_frame + cnt_addr, 0);
        send(0, 5'h01, 8'h80, mk_reply(0, 5'h1A, 0, 8'h00, 1));
        repeat (20) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule